// File: doc/BRIEF.md
# Stopwatch with Lap Capture

This core keeps elapsed time for a stopwatch as four base-10 digits (minutes tens, minutes units, seconds tens, seconds units). Two active-low push buttons are sampled on the system clock. A press is the first clock edge at which a button reads low after reading high. The mode button rotates a one-hot mode through cleared, running and stopped. The lap button freezes a copy of the time on the display while counting carries on underneath.

Time advances on a single-cycle tick enable supplied from outside, one pulse per second. Each digit is its own 4-bit counter that wraps and carries into its neighbour, so the display digits come out directly as BCD with no division. The output is a packed vector of BCD digits for external segment decoders. It shows either the live count or the captured lap value, and a flag reports which one is shown.

Top module: `stopwatch_lap`

## Requirements
- R1: After reset the mode is cleared (modeOh = 3'b001; bit 0 cleared, bit 1 running, bit 2 stopped), every display digit is zero and showLap is 0; exactly one mode bit is high at all times.
- R2: A mode press steps cleared to running, running to stopped, and stopped to cleared, at the first clock edge that samples modeKeyN low after it was high.
- R3: A mode button held low for many cycles advances the mode exactly once, and its release changes nothing.
- R4: The live digits advance by one on each clock edge with tickEn high only while running; ticks in the stopped mode leave the digits unchanged, and ticks in the cleared mode leave them at zero.
- R5: dispDigits packs seconds units in [3:0] and seconds tens in [7:4]; seconds units wrap 9 to 0 and carry into seconds tens, which wrap 5 to 0 and carry into minutes units.
- R6: Minutes units in [11:8] wrap 9 to 0 and carry into minutes tens in [15:12], which wrap 9 to 0, so 99:59 plus one tick reads 00:00.
- R7: In the cleared mode the display reads all zeros, starting at the same edge that enters the cleared mode.
- R8: A lap press while the live time is shown captures the live time at that edge and sets showLap; the display then holds that value while ticks keep advancing the hidden live count.
- R9: A lap press while the lap is shown clears showLap, and the display shows the current live count.
- R10: A mode press clears showLap and shows live time; when both buttons are pressed at the same edge, the mode change applies and showLap ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeKeyN | input | 1 | Mode button, active low |
| lapKeyN | input | 1 | Lap button, active low |
| tickEn | input | 1 | One-cycle time unit enable |
| modeOh | output | 3 | One-hot mode: bit0 cleared, bit1 running, bit2 stopped |
| showLap | output | 1 | High when the lap value is displayed |
| dispDigits | output | 16 | Packed BCD digits, seconds units lowest |

## Verification
Every result lands at the first rising edge after the stimulus is seen, because the press detector is combinational against a one-deep history register. A mode or lap press is therefore visible on modeOh, showLap and dispDigits at that edge, and n tick-enabled edges give an exact count of n. The bench changes inputs at falling edges and reads outputs at the next falling edge, half a period after the edge that applies them. For a held button, it reads the outputs again after many more edges and after the release, to show that no further step occurs.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [2:0] MODE_CLEAR = 3'b001;
  localparam logic [2:0] MODE_RUN   = 3'b010;
  localparam logic [2:0] MODE_STOP  = 3'b100;

  typedef struct packed {
    logic clearTime;
    logic countEn;
    logic lapLoad;
    logic showLap;
  } ctrlStrobes_t;

  // Odd positions below the top digit are tens of a base-60 field.
  function automatic logic [DIGIT_W-1:0] digitLimit(input int idx, input int numDigits);
    if ((idx % 2 == 1) && (idx != numDigits - 1)) return DIGIT_W'(5);
    return DIGIT_W'(9);
  endfunction
endpackage

// File: rtl/sw_press_detect.sv
module sw_press_detect #(
  parameter int N_KEYS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_KEYS-1:0] keyN,
  output logic [N_KEYS-1:0] pressed
);
  logic [N_KEYS-1:0] keyPrev;

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) keyPrev[k] <= 1'b1;
      else       keyPrev[k] <= keyN[k];
    end
    assign pressed[k] = keyPrev[k] & ~keyN[k];
  end
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import stopwatch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modePress,
  input  logic         lapPress,
  input  logic         tickEn,
  output logic [2:0]   modeOh,
  output ctrlStrobes_t strobes
);
  logic [2:0] modeQ;
  logic       showQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_CLEAR;
      showQ <= 1'b0;
    end else begin
      if (modePress) modeQ <= {modeQ[1:0], modeQ[2]};
      if (modePress)     showQ <= 1'b0;
      else if (lapPress) showQ <= ~showQ;
    end
  end

  always_comb begin
    strobes.clearTime = modeQ[0] | (modePress & modeQ[2]);
    strobes.countEn   = tickEn & modeQ[1];
    strobes.lapLoad   = lapPress & ~showQ & ~modePress;
    strobes.showLap   = showQ;
  end

  assign modeOh = modeQ;
endmodule

// File: rtl/sw_datapath.sv
module sw_datapath
  import stopwatch_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int VEC_W = NUM_DIGITS * DIGIT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic [VEC_W-1:0] dispDigits
);
  logic [NUM_DIGITS-1:0] carry;
  logic [VEC_W-1:0]      liveVec;
  logic [VEC_W-1:0]      lapQ;

  assign carry[0] = strobes.countEn;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    localparam logic [DIGIT_W-1:0] LIM = digitLimit(i, NUM_DIGITS);
    logic [DIGIT_W-1:0] digitQ;
    logic               atLim;

    assign atLim = (digitQ == LIM);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  digitQ <= '0;
      else if (strobes.clearTime) digitQ <= '0;
      else if (carry[i])          digitQ <= atLim ? '0 : digitQ + DIGIT_W'(1);
    end

    assign liveVec[i*DIGIT_W +: DIGIT_W] = digitQ;

    if (i < NUM_DIGITS - 1) begin : g_carry
      assign carry[i+1] = carry[i] & atLim;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lapQ <= '0;
    else if (strobes.lapLoad) lapQ <= liveVec;
  end

  assign dispDigits = strobes.showLap ? lapQ : liveVec;
endmodule

// File: rtl/stopwatch_lap.sv
module stopwatch_lap
  import stopwatch_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modeKeyN,
  input  logic                          lapKeyN,
  input  logic                          tickEn,
  output logic [2:0]                    modeOh,
  output logic                          showLap,
  output logic [NUM_DIGITS*DIGIT_W-1:0] dispDigits
);
  logic [1:0]   pressed;
  ctrlStrobes_t strobes;

  sw_press_detect #(.N_KEYS(2)) press_i (
    .clk(clk), .rstN(rstN), .keyN({lapKeyN, modeKeyN}), .pressed(pressed)
  );

  sw_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modePress(pressed[0]), .lapPress(pressed[1]),
    .tickEn(tickEn), .modeOh(modeOh), .strobes(strobes)
  );

  sw_datapath #(.NUM_DIGITS(NUM_DIGITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dispDigits(dispDigits)
  );

  assign showLap = strobes.showLap;
endmodule

// File: rtl/stopwatch_lap_chk.sv
module stopwatch_lap_chk
  import stopwatch_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          modeKeyN,
  input logic                          lapKeyN,
  input logic                          tickEn,
  input logic [2:0]                    modeOh,
  input logic                          showLap,
  input logic [NUM_DIGITS*DIGIT_W-1:0] dispDigits
);
  logic modeSeen, lapSeen;
  logic modeFall, lapFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSeen <= 1'b1;
      lapSeen  <= 1'b1;
    end else begin
      modeSeen <= modeKeyN;
      lapSeen  <= lapKeyN;
    end
  end

  assign modeFall = modeSeen & ~modeKeyN;
  assign lapFall  = lapSeen & ~lapKeyN;

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeOh) == 1); // R1

  AST_MODE_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    modeFall |=> modeOh == {$past(modeOh[1:0]), $past(modeOh[2])}); // R2

  AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !modeFall |=> $stable(modeOh)); // R3

  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (modeOh == MODE_STOP && !modeFall && !lapFall) |=> $stable(dispDigits)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (modeOh == MODE_CLEAR) |-> (dispDigits == '0)); // R7

  AST_LAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (showLap && !lapFall && !modeFall) |=> $stable(dispDigits)); // R8

  AST_MODE_DROPS_LAP: assert property (@(posedge clk) disable iff (!rstN)
    modeFall |=> !showLap); // R10

  AST_LAP_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (lapFall && !modeFall) |=> showLap != $past(showLap)); // R9

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_rng
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      dispDigits[i*DIGIT_W +: DIGIT_W] <= digitLimit(i, NUM_DIGITS)); // R5
  end
endmodule

bind stopwatch_lap stopwatch_lap_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk(clk), .rstN(rstN), .modeKeyN(modeKeyN), .lapKeyN(lapKeyN),
  .tickEn(tickEn), .modeOh(modeOh), .showLap(showLap), .dispDigits(dispDigits)
);

// File: tb/stopwatch_lap_tb_top.sv
module stopwatch_lap_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeKeyN = 1'b1;
  logic        lapKeyN = 1'b1;
  logic        tickEn = 1'b0;
  logic [2:0]  modeOh;
  logic        showLap;
  logic [15:0] dispDigits;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  stopwatch_lap #(.NUM_DIGITS(4)) dut_i (
    .clk(clk), .rstN(rstN), .modeKeyN(modeKeyN), .lapKeyN(lapKeyN),
    .tickEn(tickEn), .modeOh(modeOh), .showLap(showLap), .dispDigits(dispDigits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    @(negedge clk) tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic pressMode();
    @(negedge clk) modeKeyN = 1'b0;
    @(negedge clk) modeKeyN = 1'b1;
  endtask

  task automatic pressLap();
    @(negedge clk) lapKeyN = 1'b0;
    @(negedge clk) lapKeyN = 1'b1;
  endtask

  task automatic testReset();
    chk("R1 mode", 32'(modeOh), 32'h1);
    chk("R1 digits", 32'(dispDigits), 32'h0);
    chk("R1 showLap", 32'(showLap), 32'h0);
    runTicks(5);
    chk("R4 cleared ignores ticks", 32'(dispDigits), 32'h0);
  endtask

  task automatic testRunStop();
    pressMode();
    chk("R2 cleared->running", 32'(modeOh), 32'h2);
    runTicks(12);
    chk("R4 R5 count 12", 32'(dispDigits), 32'h0012);
    @(negedge clk) modeKeyN = 1'b0;
    @(negedge clk);
    chk("R2 running->stopped", 32'(modeOh), 32'h4);
    repeat (10) @(negedge clk);
    chk("R3 held press one step", 32'(modeOh), 32'h4);
    modeKeyN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 release no step", 32'(modeOh), 32'h4);
    runTicks(5);
    chk("R4 stopped holds", 32'(dispDigits), 32'h0012);
    pressMode();
    chk("R2 stopped->cleared", 32'(modeOh), 32'h1);
    chk("R7 cleared zeroes", 32'(dispDigits), 32'h0);
  endtask

  task automatic testCarries();
    pressMode();
    runTicks(59);
    chk("R5 at 00:59", 32'(dispDigits), 32'h0059);
    runTicks(1);
    chk("R5 carry to minutes", 32'(dispDigits), 32'h0100);
    runTicks(539);
    chk("R6 at 09:59", 32'(dispDigits), 32'h0959);
    runTicks(1);
    chk("R6 carry to minute tens", 32'(dispDigits), 32'h1000);
    runTicks(5399);
    chk("R6 at 99:59", 32'(dispDigits), 32'h9959);
    runTicks(1);
    chk("R6 full wrap", 32'(dispDigits), 32'h0000);
  endtask

  task automatic testLap();
    runTicks(7);
    pressLap();
    chk("R8 lap shown", 32'(showLap), 32'h1);
    chk("R8 lap value", 32'(dispDigits), 32'h0007);
    runTicks(5);
    chk("R8 lap frozen", 32'(dispDigits), 32'h0007);
    pressLap();
    chk("R9 back to live", 32'(showLap), 32'h0);
    chk("R9 live value", 32'(dispDigits), 32'h0012);
    pressLap();
    runTicks(3);
    pressMode();
    chk("R10 mode drops lap", 32'(showLap), 32'h0);
    chk("R10 live after mode", 32'(dispDigits), 32'h0015);
    chk("R10 stopped", 32'(modeOh), 32'h4);
    @(negedge clk) begin modeKeyN = 1'b0; lapKeyN = 1'b0; end
    @(negedge clk) begin modeKeyN = 1'b1; lapKeyN = 1'b1; end
    chk("R10 both keys mode wins", 32'(modeOh), 32'h1);
    chk("R10 both keys no lap", 32'(showLap), 32'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRunStop();
    testCarries();
    testLap();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule